// File: doc/BRIEF.md
# Programmable Baud Clock Divider Bank

The block holds sixteen independent clock dividers that run from the core clock and a configuration engine that sets them up. A request names one generator, a sample rate and an oversampling multiplier. The engine divides the generator input clock by the product of rate and multiplier. The generator input clock is half the core clock, and the division truncates. The engine then shapes the result into a control word and stores the word in the named generator. Divisors above what the divider field can hold switch on a divide-by-16 prescaler. Odd divisors above three are raised to the next even value when the prescaler is off.

Each programmed generator gives out a one-core-cycle tick at the rate that its stored word selects. A transmit or receive engine uses these ticks as its sampling strobe. The quotient comes from an iterative divider, so a request takes a fixed number of cycles, and the engine accepts no new request until the current one has finished. A request that cannot be met is reported as an error and leaves every generator as it was.

Top module: `brg_bank`

## Requirements
- R1: After reset, cfg_busy, cfg_done and every bit of brg_tick are 0.
- R2: cfg_sel selects a generator by a value from 1 to NUM_GEN, where 1 is brg_tick[0]. Any other value completes with cfg_err=1.
- R3: The raw divisor is floor((CORE_HZ/2) / (cfg_rate*cfg_mult)). A product of zero or a raw divisor of zero completes with cfg_err=1.
- R4: When the raw divisor is greater than 2^FIELD_W (4096), the prescale bit is set and the divisor becomes floor(raw/16).
- R5: When the prescale bit is clear and the divisor is odd and greater than 3, the divisor is raised by one. Divisors of 1 and 3 are kept.
- R6: The control word carries the prescale flag in bit 0, divisor-1 in bits 12:1 and a 1 in bit 16, with 0 in every other bit. A prescaled divisor above 4096 completes with cfg_err=1, and every error gives a cfg_word of 0.
- R7: A request is accepted on a cycle with cfg_start=1 and cfg_busy=0. cfg_busy stays 1 until the result appears. cfg_done is a one-cycle pulse that carries cfg_err and cfg_word, and a cfg_start while busy is ignored.
- R8: A programmed generator pulses its brg_tick bit for one cycle every 2*(divisor) core cycles, or every 32*(divisor) core cycles with the prescale bit set.
- R9: A generator that has never been programmed gives no ticks.
- R10: A request that ends in an error changes no generator's setting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_start | input | 1 | Request strobe |
| cfg_sel | input | 5 | Generator number, 1-based |
| cfg_rate | input | 24 | Requested sample rate |
| cfg_mult | input | 6 | Oversampling multiplier |
| cfg_busy | output | 1 | Request in progress |
| cfg_done | output | 1 | One-cycle result strobe |
| cfg_err | output | 1 | Request rejected, valid with cfg_done |
| cfg_word | output | 17 | Control word written, valid with cfg_done |
| brg_tick | output | 16 | Per-generator one-cycle tick |

## Verification
The assertions assume that reset is held long enough for the core-clock half-rate phase to start cleanly. They also assume that a stored control word changes only through a successful request. Under these assumptions the ticks, the done pulse and the word fields can be checked against one another. The stimulus raises cfg_start only for single cycles. It keeps cfg_rate and cfg_mult within their port widths, and it mixes random requests with directed ones at the 4095, 4096 and 4097 divisor boundaries, at zero products and at out-of-range selections. Random requests never target generators 14 to 16, so those generators must stay silent, apart from one request issued while the engine is busy, which must be ignored.

// File: rtl/brg_pkg.sv
package brg_pkg;
   typedef enum logic [1:0] {
      CFG_IDLE = 2'd0,
      CFG_DIV  = 2'd1
   } cfg_state_e;

   localparam int PRE_BIT   = 0;
   localparam int FIELD_LSB = 1;
endpackage

// File: rtl/brg_divider.sv
module brg_divider #(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         start,
   input  logic [W-1:0] dividend,
   input  logic [W-1:0] divisor,
   output logic         busy,
   output logic         done,
   output logic [W-1:0] quotient
);
   localparam int CW = $clog2(W + 1);

   logic [W-1:0]  rem_q, den_q;
   logic [CW-1:0] step_q;
   logic [W:0]    rem_sh;

   assign rem_sh = {rem_q, quotient[W-1]};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy     <= 1'b0;
         done     <= 1'b0;
         rem_q    <= '0;
         den_q    <= '0;
         quotient <= '0;
         step_q   <= '0;
      end else begin
         done <= 1'b0;
         if (start && !busy) begin
            busy     <= 1'b1;
            rem_q    <= '0;
            den_q    <= divisor;
            quotient <= dividend;
            step_q   <= '0;
         end else if (busy) begin
            if (rem_sh >= {1'b0, den_q}) begin
               rem_q    <= W'(rem_sh - {1'b0, den_q});
               quotient <= {quotient[W-2:0], 1'b1};
            end else begin
               rem_q    <= rem_sh[W-1:0];
               quotient <= {quotient[W-2:0], 1'b0};
            end
            step_q <= step_q + 1'b1;
            if (step_q == CW'(W - 1)) begin
               busy <= 1'b0;
               done <= 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/brg_encode.sv
module brg_encode #(
   parameter int DIV_W    = 32,
   parameter int FIELD_W  = 12,
   parameter int PRE_LOG2 = 4,
   parameter int WORD_W   = 17,
   parameter int EN_BIT   = 16
) (
   input  logic [DIV_W-1:0]  raw,
   input  logic              sel_ok,
   input  logic              prod_zero,
   output logic              err,
   output logic              pre,
   output logic [FIELD_W-1:0] field,
   output logic [WORD_W-1:0] word
);
   import brg_pkg::*;
   localparam logic [DIV_W-1:0] LIM = DIV_W'(1) << FIELD_W;

   logic [DIV_W-1:0] div;

   always_comb begin
      pre = raw > LIM;
      div = pre ? (raw >> PRE_LOG2) : raw;
      if (!pre && div[0] && div > DIV_W'(3))
         div = div + 1'b1;
      err   = !sel_ok || prod_zero || raw == '0 || div > LIM;
      field = FIELD_W'(div - 1'b1);
      word  = '0;
      if (!err) begin
         word[PRE_BIT]                       = pre;
         word[FIELD_LSB +: FIELD_W]          = field;
         word[EN_BIT]                        = 1'b1;
      end
   end
endmodule

// File: rtl/brg_gen.sv
module brg_gen #(
   parameter int FIELD_W  = 12,
   parameter int PRE_LOG2 = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               ref_tick,
   input  logic               wr,
   input  logic               wr_pre,
   input  logic [FIELD_W-1:0] wr_field,
   output logic               en,
   output logic               tick
);
   logic               pre_q;
   logic [FIELD_W-1:0] field_q, dcnt_q;
   logic [PRE_LOG2-1:0] pcnt_q;
   logic               pwrap;

   assign pwrap = !pre_q || (&pcnt_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en      <= 1'b0;
         pre_q   <= 1'b0;
         field_q <= '0;
         dcnt_q  <= '0;
         pcnt_q  <= '0;
         tick    <= 1'b0;
      end else if (wr) begin
         en      <= 1'b1;
         pre_q   <= wr_pre;
         field_q <= wr_field;
         dcnt_q  <= '0;
         pcnt_q  <= '0;
         tick    <= 1'b0;
      end else if (!en) begin
         dcnt_q <= '0;
         pcnt_q <= '0;
         tick   <= 1'b0;
      end else begin
         tick <= 1'b0;
         if (ref_tick) begin
            pcnt_q <= pre_q ? pcnt_q + 1'b1 : '0;
            if (pwrap) begin
               if (dcnt_q == field_q) begin
                  dcnt_q <= '0;
                  tick   <= 1'b1;
               end else begin
                  dcnt_q <= dcnt_q + 1'b1;
               end
            end
         end
      end
   end
endmodule

// File: rtl/brg_bank.sv
module brg_bank #(
   parameter int NUM_GEN  = 16,
   parameter int SEL_W    = 5,
   parameter int RATE_W   = 24,
   parameter int MULT_W   = 6,
   parameter int DIV_W    = 32,
   parameter int FIELD_W  = 12,
   parameter int PRE_LOG2 = 4,
   parameter longint CORE_HZ = 100_000_000
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cfg_start,
   input  logic [SEL_W-1:0]   cfg_sel,
   input  logic [RATE_W-1:0]  cfg_rate,
   input  logic [MULT_W-1:0]  cfg_mult,
   output logic               cfg_busy,
   output logic               cfg_done,
   output logic               cfg_err,
   output logic [FIELD_W+4:0] cfg_word,
   output logic [NUM_GEN-1:0] brg_tick
);
   import brg_pkg::*;
   localparam int EN_BIT = FIELD_LSB + FIELD_W + 3;
   localparam int WORD_W = EN_BIT + 1;
   localparam logic [DIV_W-1:0] SRC_HZ = DIV_W'(CORE_HZ / 2);

   if (RATE_W + MULT_W > DIV_W) begin : g_bad_prod
      $error("rate times multiplier does not fit the divider width");
   end
   if ((1 << SEL_W) <= NUM_GEN) begin : g_bad_sel
      $error("select width too small for generator count");
   end
   if (CORE_HZ / 2 >= (longint'(1) << DIV_W)) begin : g_bad_hz
      $error("core frequency does not fit the divider width");
   end

   cfg_state_e         state_q;
   logic [SEL_W-1:0]   sel_q;
   logic               sel_ok_q, prod_zero_q;
   logic [DIV_W-1:0]   prod;
   logic               div_busy, div_done;
   logic [DIV_W-1:0]   raw;
   logic               enc_err, enc_pre;
   logic [FIELD_W-1:0] enc_field;
   logic [WORD_W-1:0]  enc_word;
   logic               ref_tick;
   logic [NUM_GEN-1:0] gen_en;
   logic               accept;

   assign prod   = DIV_W'(cfg_rate) * DIV_W'(cfg_mult);
   assign accept = cfg_start && state_q == CFG_IDLE;
   assign cfg_busy = state_q != CFG_IDLE;

   brg_divider #(.W(DIV_W)) div_i (
      .clk(clk), .rst_n(rst_n), .start(accept),
      .dividend(SRC_HZ), .divisor(prod),
      .busy(div_busy), .done(div_done), .quotient(raw)
   );

   brg_encode #(
      .DIV_W(DIV_W), .FIELD_W(FIELD_W), .PRE_LOG2(PRE_LOG2),
      .WORD_W(WORD_W), .EN_BIT(EN_BIT)
   ) enc_i (
      .raw(raw), .sel_ok(sel_ok_q), .prod_zero(prod_zero_q),
      .err(enc_err), .pre(enc_pre), .field(enc_field), .word(enc_word)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q     <= CFG_IDLE;
         sel_q       <= '0;
         sel_ok_q    <= 1'b0;
         prod_zero_q <= 1'b0;
         cfg_done    <= 1'b0;
         cfg_err     <= 1'b0;
         cfg_word    <= '0;
         ref_tick    <= 1'b0;
      end else begin
         ref_tick <= ~ref_tick;
         cfg_done <= 1'b0;
         if (accept) begin
            state_q     <= CFG_DIV;
            sel_q       <= cfg_sel;
            sel_ok_q    <= cfg_sel >= SEL_W'(1) && cfg_sel <= SEL_W'(NUM_GEN);
            prod_zero_q <= prod == '0;
         end else if (state_q == CFG_DIV && div_done) begin
            state_q  <= CFG_IDLE;
            cfg_done <= 1'b1;
            cfg_err  <= enc_err;
            cfg_word <= enc_word;
         end
      end
   end

   for (genvar g = 0; g < NUM_GEN; g++) begin : g_gen
      logic wr;
      assign wr = state_q == CFG_DIV && div_done && !enc_err &&
                  sel_q == SEL_W'(g + 1);
      brg_gen #(.FIELD_W(FIELD_W), .PRE_LOG2(PRE_LOG2)) gen_i (
         .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick),
         .wr(wr), .wr_pre(enc_pre), .wr_field(enc_field),
         .en(gen_en[g]), .tick(brg_tick[g])
      );
   end

   logic unused_busy;
   assign unused_busy = div_busy;
endmodule

// File: rtl/brg_bank_chk.sv
module brg_bank_chk #(
   parameter int NUM_GEN = 16,
   parameter int WORD_W  = 17
) (
   input logic               clk,
   input logic               rst_n,
   input logic               cfg_busy,
   input logic               cfg_done,
   input logic               cfg_err,
   input logic [WORD_W-1:0]  cfg_word,
   input logic [NUM_GEN-1:0] brg_tick,
   input logic [NUM_GEN-1:0] gen_en
);
   assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_done |=> !cfg_done);

   assert_done_after_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_done |-> $past(cfg_busy) && !cfg_busy);

   assert_err_word_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_done && cfg_err) |-> cfg_word == '0);

   assert_word_enable_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_done && !cfg_err) |-> cfg_word[WORD_W-1]);

   assert_even_div_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_done && !cfg_err && !cfg_word[0]) |->
         (cfg_word[1] || cfg_word[12:1] <= 12'd2));

   assert_prescale_floor_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_done && !cfg_err && cfg_word[0]) |-> cfg_word[12:1] >= 12'd255);

   assert_tick_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
      brg_tick != '0 |=> (brg_tick & $past(brg_tick)) == '0);

   assert_tick_enabled_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (brg_tick & ~gen_en) == '0);
endmodule

bind brg_bank brg_bank_chk #(.NUM_GEN(NUM_GEN), .WORD_W(WORD_W)) chk_i (
   .clk(clk), .rst_n(rst_n), .cfg_busy(cfg_busy), .cfg_done(cfg_done),
   .cfg_err(cfg_err), .cfg_word(cfg_word), .brg_tick(brg_tick),
   .gen_en(gen_en)
);

// File: tb/brg_bank_tb_top.sv
module brg_bank_tb_top;
   localparam longint SRC = 50_000_000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_start = 1'b0;
   logic [4:0]  cfg_sel = '0;
   logic [23:0] cfg_rate = '0;
   logic [5:0]  cfg_mult = '0;
   logic        cfg_busy, cfg_done, cfg_err;
   logic [16:0] cfg_word;
   logic [15:0] brg_tick;

   int checks = 0, failures = 0;
   longint cyc = 0;
   int silent_ticks = 0;
   bit finished = 0;

   always #5 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;
   always @(negedge clk) if (rst_n && (brg_tick[15:13] != 0)) silent_ticks++;

   brg_bank dut_i (
      .clk(clk), .rst_n(rst_n), .cfg_start(cfg_start), .cfg_sel(cfg_sel),
      .cfg_rate(cfg_rate), .cfg_mult(cfg_mult), .cfg_busy(cfg_busy),
      .cfg_done(cfg_done), .cfg_err(cfg_err), .cfg_word(cfg_word),
      .brg_tick(brg_tick)
   );

   task automatic check(input bit ok, input string req, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic void model(input int sel, input longint rate, input longint mult,
                                 output bit err, output logic [16:0] word);
      longint prod, raw, div;
      bit pre;
      prod = rate * mult;
      err = (sel < 1) || (sel > 16) || (prod == 0);
      raw = (prod == 0) ? 0 : SRC / prod;
      pre = raw > 4096;
      div = pre ? raw / 16 : raw;
      if (!pre && (div % 2 == 1) && div > 3) div++;
      if (raw == 0 || div > 4096) err = 1;
      word = '0;
      if (!err) begin
         word[0] = pre;
         word[12:1] = 12'(div - 1);
         word[16] = 1'b1;
      end
   endfunction

   task automatic request(input int sel, input int rate, input int mult,
                          output bit err, output logic [16:0] word);
      @(negedge clk);
      cfg_sel = 5'(sel); cfg_rate = 24'(rate); cfg_mult = 6'(mult); cfg_start = 1'b1;
      @(negedge clk);
      cfg_start = 1'b0;
      err = 1'b1; word = '0;
      for (int i = 0; i < 100; i++) begin
         if (cfg_done) begin err = cfg_err; word = cfg_word; break; end
         @(negedge clk);
      end
   endtask

   task automatic req_check(input int sel, input int rate, input int mult, input string tag);
      bit err, eerr;
      logic [16:0] word, eword;
      request(sel, rate, mult, err, word);
      model(sel, rate, mult, eerr, eword);
      check(err == eerr, {tag, " err"}, err, eerr);
      check(word == eword, {tag, " word"}, word, eword);
   endtask

   task automatic period(input int g, input longint exp, input string tag);
      longint t0 = -1, t1 = -1;
      for (longint i = 0; i < 3 * exp + 100; i++) begin
         @(negedge clk);
         if (brg_tick[g]) begin
            if (t0 < 0) t0 = cyc;
            else begin t1 = cyc; break; end
         end
      end
      check(t1 >= 0 && (t1 - t0) == exp, tag, t1 - t0, exp);
   endtask

   initial begin
      bit err; logic [16:0] word; int nd;
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check(!cfg_busy && !cfg_done && brg_tick == 0, "R1 reset", {cfg_busy, cfg_done}, 0);

      // R3 R8 divisor 10, period 20
      req_check(2, 625000, 8, "R3 div10");
      period(1, 20, "R8 period div10");
      // R5 odd 7 -> 8
      req_check(3, 7142857, 1, "R5 odd7");
      period(2, 16, "R8 period div8");
      // R5 odd 3 kept, 1 kept
      req_check(4, 16666666, 1, "R5 odd3");
      period(3, 6, "R8 period div3");
      req_check(5, 12500000, 4, "R5 div1");
      period(4, 2, "R8 period div1");
      // boundaries
      req_check(6, 12210, 1, "R5 raw4095");
      req_check(7, 12207, 1, "R4 raw4096");
      req_check(8, 12204, 1, "R4 raw4097");
      req_check(9, 10000, 1, "R4 raw5000");
      period(8, 9984, "R8 prescale period");
      // errors
      req_check(10, 1, 1, "R6 range err");
      req_check(10, 0, 8, "R3 zero product");
      req_check(10, 15000000, 4, "R3 zero raw");
      req_check(0, 625000, 8, "R2 sel0");
      req_check(17, 625000, 8, "R2 sel17");
      // R10 failed request to gen 2 keeps it
      req_check(2, 0, 1, "R10 err req");
      period(1, 20, "R10 gen2 unchanged");
      // R7 start while busy ignored
      @(negedge clk);
      cfg_sel = 5'd1; cfg_rate = 24'd625000; cfg_mult = 6'd8; cfg_start = 1'b1;
      @(negedge clk);
      check(cfg_busy, "R7 busy", cfg_busy, 1);
      cfg_sel = 5'd15; cfg_start = 1'b1;
      @(negedge clk);
      cfg_start = 1'b0;
      nd = 0;
      for (int i = 0; i < 120; i++) begin
         if (cfg_done) nd++;
         @(negedge clk);
      end
      check(nd == 1, "R7 single done", nd, 1);
      check(!cfg_busy, "R7 idle", cfg_busy, 0);
      period(0, 20, "R7 first request kept");
      // random mix
      for (int n = 0; n < 24; n++) begin
         int sel, rate, mult, pick;
         pick = $urandom_range(0, 14);
         sel = (pick == 14) ? 17 : pick;
         rate = $urandom_range(1, 3000000);
         case ($urandom_range(0, 3))
            0: mult = 1; 1: mult = 8; 2: mult = 16; default: mult = 32;
         endcase
         req_check(sel, rate, mult, "R6 random");
      end
      repeat (200) @(negedge clk);
      check(silent_ticks == 0, "R9 silent generators", silent_ticks, 0);
      if (!finished) begin
         finished = 1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         checks++; failures++;
         $display("FAIL watchdog actual=%0d expected=0", cyc);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule